// File: doc/BRIEF.md
# Timer Output-Compare PWM Channel

This block is a 16-bit up-counter with a programmable wrap limit and a power-of-two clock divider. The counter drives a single output-compare pin. The pin carries a PWM waveform that two separate events build.

The first event is the wrap, when the counter passes from its limit back to zero. The wrap inverts the pin. The second event is a compare hit, when the counter reaches the compare value. A hit forces the pin to a level that a polarity input selects. The wrap limit fixes the period and the compare value fixes the pulse width.

The compare value is used directly and has no shadow copy. A new value therefore acts within the period that is running. A halt input freezes the timebase and leaves the pin where it is.

Top module: `timpwm_channel`

## Requirements
- R1: While `rst` is high at a clock edge, `count_o` becomes 0 and `pwm_o` takes the level of `match_sets` (its inactive level).
- R2: The counter steps 0, 1, …, `period_lim` and then returns to 0 on the next advance. One PWM period is therefore (`period_lim`+1)·2^N clock cycles.
- R3: `div_sel` = N advances the counter once every 2^N clock cycles for N = 0..6. The code 7 acts as 6.
- R4: Each time the counter wraps from `period_lim` to 0, `pwm_o` inverts in the same clock edge.
- R5: When the counter steps onto `match_val`, `pwm_o` is forced to the value of `match_sets`. 0 clears the pin, which gives a high-true pulse. 1 sets the pin, which gives a low-true pulse. The active pulse lasts `match_val`·2^N cycles after the wrap.
- R6: A wrap and a hit can occur on the same edge when `match_val` = 0. The forced level then wins over the inversion. With `match_sets`=0 the pin stays low, and with `match_sets`=1 it stays high.
- R7: If `match_val` > `period_lim`, no hit occurs. `pwm_o` then toggles only on wraps, giving equal high and low phases of (`period_lim`+1)·2^N cycles each.
- R8: A change to `match_val` during a period takes effect in that same period.
- R9: While `halt` is high, the counter and the divider hold their values and `pwm_o` holds its level. Counting resumes from the held value once `halt` falls.
- R10: With `period_lim`=255, N=0 and `match_val`=128 in clear mode, the pin is high for 128 cycles and low for 128 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze counter and divider |
| period_lim | input | 16 | Wrap limit (last count value) |
| div_sel | input | 3 | Divider select, divide by 2^N |
| match_val | input | 16 | Compare value, used unbuffered |
| match_sets | input | 1 | 0: hit clears pin, 1: hit sets pin |
| pwm_o | output | 1 | Output-compare pin |
| count_o | output | 16 | Current counter value |

## Verification
The wrap inversion and the compare force are the two actions that can land on one edge. This happens whenever the compare value is zero, because the counter steps onto 0 at the wrap itself. The bench provokes this with `match_val`=0 in both polarities. It judges the result by sampling the pin over several full periods, where it must never leave the forced level. A compare value above the limit is also driven, so that the wrap acts alone, and a mid-period compare rewrite moves the hit inside the same period.

// File: rtl/timpwm_pkg.sv
package timpwm_pkg;

    localparam int unsigned TIM_CNT_W   = 16;
    localparam int unsigned TIM_SEL_W   = 3;
    localparam int unsigned TIM_MAX_EXP = 6;

    typedef enum logic [1:0] {
        PIN_HOLD   = 2'd0,
        PIN_INVERT = 2'd1,
        PIN_FORCE  = 2'd2
    } pin_act_e;

    typedef struct packed {
        logic adv;
        logic wrap;
        logic hit;
    } tim_evt_t;

    function automatic int unsigned clamp_exp(input int unsigned sel, input int unsigned lim);
        return (sel > lim) ? lim : sel;
    endfunction

    function automatic pin_act_e pick_action(input tim_evt_t ev);
        if (ev.hit)       return PIN_FORCE;
        else if (ev.wrap) return PIN_INVERT;
        else              return PIN_HOLD;
    endfunction

endpackage

// File: rtl/tim_prescaler.sv
module tim_prescaler #(
    parameter int unsigned SEL_W   = timpwm_pkg::TIM_SEL_W,
    parameter int unsigned MAX_EXP = timpwm_pkg::TIM_MAX_EXP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned DIV_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [DIV_W-1:0]   div_q;
    logic [MAX_EXP:0]   low_ones;
    int unsigned        eff;

    assign low_ones[0] = 1'b1;
    genvar k;
    generate
        for (k = 1; k <= MAX_EXP; k++) begin : g_ones
            assign low_ones[k] = low_ones[k-1] & div_q[k-1];
        end
    endgenerate

    always_comb begin
        eff  = timpwm_pkg::clamp_exp(int'(sel), MAX_EXP);
        tick = low_ones[eff];
    end

    always_ff @(posedge clk) begin
        if (rst)        div_q <= '0;
        else if (!halt) div_q <= div_q + 1'b1;
    end

    AST_PSC_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> tick); // R3
    AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(div_q)); // R9

endmodule

// File: rtl/tim_counter.sv
module tim_counter #(
    parameter int unsigned CNT_W = timpwm_pkg::TIM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             at_lim
);
    always_comb begin
        at_lim  = (cnt_q == limit);
        cnt_nxt = at_lim ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (adv) cnt_q <= cnt_nxt;
    end

    AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_q == limit) |=> (cnt_q == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_q != limit) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/tim_oc_channel.sv
module tim_oc_channel #(
    parameter int unsigned CNT_W = timpwm_pkg::TIM_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             at_lim,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             set_mode,
    output logic             pin
);
    import timpwm_pkg::*;

    tim_evt_t ev;
    pin_act_e act;

    always_comb begin
        ev.adv  = adv;
        ev.wrap = adv && at_lim;
        ev.hit  = adv && (cnt_nxt == cmp);
        act     = pick_action(ev);
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= set_mode;
        else begin
            unique case (act)
                PIN_FORCE:  pin <= set_mode;
                PIN_INVERT: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end

    AST_PIN_INVERT: assert property (@(posedge clk) disable iff (rst)
        (adv && at_lim && cnt_nxt != cmp) |=> (pin != $past(pin))); // R4
    AST_PIN_FORCE: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_nxt == cmp) |=> (pin == $past(set_mode))); // R5
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pin)); // R9

endmodule

// File: rtl/timpwm_channel.sv
module timpwm_channel #(
    parameter int unsigned CNT_W   = timpwm_pkg::TIM_CNT_W,
    parameter int unsigned SEL_W   = timpwm_pkg::TIM_SEL_W,
    parameter int unsigned MAX_EXP = timpwm_pkg::TIM_MAX_EXP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic [CNT_W-1:0] period_lim,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] match_val,
    input  logic             match_sets,
    output logic             pwm_o,
    output logic [CNT_W-1:0] count_o
);
    logic             tick;
    logic             adv;
    logic             at_lim;
    logic [CNT_W-1:0] cnt_nxt;

    tim_prescaler #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .halt (halt),
        .sel  (div_sel),
        .tick (tick)
    );

    assign adv = tick && !halt;

    tim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .limit   (period_lim),
        .cnt_q   (count_o),
        .cnt_nxt (cnt_nxt),
        .at_lim  (at_lim)
    );

    tim_oc_channel #(.CNT_W(CNT_W)) u_oc (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .at_lim   (at_lim),
        .cnt_nxt  (cnt_nxt),
        .cmp      (match_val),
        .set_mode (match_sets),
        .pin      (pwm_o)
    );

    AST_TOP_HALT_PIN: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(pwm_o)); // R9
    AST_TOP_HALT_CNT: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(count_o)); // R9

endmodule

// File: tb/timpwm_channel_tb.sv
module timpwm_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        halt;
    logic [15:0] period_lim;
    logic [2:0]  div_sel;
    logic [15:0] match_val;
    logic        match_sets;
    logic        pwm_o;
    logic [15:0] count_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    timpwm_channel u_dut (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt),
        .period_lim (period_lim),
        .div_sel    (div_sel),
        .match_val  (match_val),
        .match_sets (match_sets),
        .pwm_o      (pwm_o),
        .count_o    (count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int lim, input int sel, input int cmp, input bit pol);
        @(negedge clk);
        rst = 1'b1; halt = 1'b0;
        period_lim = 16'(lim); div_sel = 3'(sel);
        match_val = 16'(cmp); match_sets = pol;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        prev = pwm_o;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (pwm_o && !prev) begin ok = 1'b1; break; end
            prev = pwm_o;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        bit ok;
        hi = 0; lo = 0;
        wait_rise(ok);
        if (!ok) return;
        hi = 1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (!pwm_o) break;
            hi++;
        end
        lo = 1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            if (pwm_o) break;
            lo++;
        end
    endtask

    task automatic t_reset;
        setup(100, 0, 30, 1'b1);
        @(negedge clk); rst = 1'b1; @(negedge clk);
        chk("R1 count in reset", count_o, 0);
        chk("R1 pin in reset (set mode)", pwm_o, 1);
        match_sets = 1'b0; @(negedge clk);
        chk("R1 pin in reset (clear mode)", pwm_o, 0);
        rst = 1'b0;
    endtask

    task automatic t_sequence;
        int exp_c;
        int bad;
        setup(5, 0, 9, 1'b0);
        @(negedge clk);
        exp_c = count_o;
        chk("R2 first count after reset", count_o, 1);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            exp_c = (exp_c == 5) ? 0 : exp_c + 1;
            if (count_o != 16'(exp_c)) bad++;
        end
        chk("R2 count sequence 0..limit", bad, 0);
    endtask

    task automatic t_main;
        int hi, lo;
        setup(255, 0, 128, 1'b0);
        measure(hi, lo);
        chk("R10 high phase", hi, 128);
        chk("R10 low phase", lo, 128);
        setup(255, 0, 64, 1'b1);
        measure(hi, lo);
        chk("R5 set-mode high phase", hi, 192);
        chk("R5 set-mode low pulse", lo, 64);
    endtask

    task automatic t_divider;
        int hi, lo;
        setup(9, 1, 3, 1'b0);
        measure(hi, lo);
        chk("R3 div2 high", hi, 6);
        chk("R3 div2 low", lo, 14);
        setup(3, 7, 1, 1'b0);
        measure(hi, lo);
        chk("R3 code7 as div64 high", hi, 64);
        chk("R3 code7 as div64 low", lo, 192);
    endtask

    task automatic t_collide;
        int highs;
        setup(49, 0, 0, 1'b0);
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        chk("R6 cmp0 clear mode stays low", highs, 0);
        setup(49, 0, 0, 1'b1);
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        chk("R6 cmp0 set mode stays high", highs, 300);
    endtask

    task automatic t_nohit;
        int hi, lo;
        setup(19, 0, 50, 1'b0);
        measure(hi, lo);
        chk("R7 toggle-only high", hi, 20);
        chk("R7 toggle-only low", lo, 20);
        chk("R4 wrap inversion gives period", hi + lo, 40);
    endtask

    task automatic t_unbuffered;
        bit ok;
        int hi;
        setup(255, 0, 200, 1'b0);
        wait_rise(ok);
        hi = 1;
        for (int g = 1; g < 400; g++) begin
            @(negedge clk);
            if (g == 10) match_val = 16'd40;
            if (!pwm_o) break;
            hi++;
        end
        chk("R8 rewritten compare in same period", hi, 40);
    endtask

    task automatic t_halt;
        logic [15:0] c0;
        logic        p0;
        int moved;
        setup(255, 0, 128, 1'b0);
        repeat (30) @(negedge clk);
        halt = 1'b1;
        c0 = count_o; p0 = pwm_o;
        moved = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (count_o != c0 || pwm_o != p0) moved++;
        end
        chk("R9 frozen while halted", moved, 0);
        halt = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 resumes from held value", count_o, int'(c0) + 5);
    endtask

    initial begin
        rst = 1'b1; halt = 1'b0; period_lim = '0; div_sel = '0;
        match_val = '0; match_sets = 1'b0;
        t_reset();
        t_sequence();
        t_main();
        t_divider();
        t_collide();
        t_nohit();
        t_unbuffered();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule